// File: doc/BRIEF.md
# Vertical FIR Multiply-Accumulate Core

This block forms the arithmetic heart of an eight-tap vertical image filter. On every clock it receives eight signed samples, one for each vertical tap: the current pixel and the same column from seven earlier lines, which are supplied by line delays outside this block. It multiplies each sample by the matching coefficient of a selected coefficient set and adds the eight products. It then either starts a new total or adds the sum into a running 32-bit total. A finished total is published on a registered result port.

There are 256 coefficient sets, each holding eight 12-bit fractional coefficients. A registered set address chooses the active set, so that the filter response can change from one pixel to the next. The address register only updates while its active-low enable is asserted. A plain synchronous write port fills the coefficient store one word at a time. A chip-level sequencer drives the accumulate control to chain sums over several cycles, which is how filters with more than eight taps are built by time-multiplexing.

Top module: `vfir_mac_core`

## Requirements
- R1: A synchronous active-low reset clears the set address, all pipeline stages, the running total and the result. `result_o` and the running total read zero on the clock after any reset edge.
- R2: Tap k is bits [12k+11:12k] of `tap_i`. It is multiplied only by coefficient k (write bank k) of the selected set.
- R3: Samples and coefficients are 12-bit two's complement. Each product, and the sum of the eight products, is formed exactly with sign extension. The result read as a signed integer equals the integer sum of the sample × coefficient products, with result LSB weight 2^-11 when coefficient LSB weight is 2^-11.
- R4: On a rising edge with `set_addr_en_n_i` low, the set address register takes `set_addr_i`. With `set_addr_en_n_i` high it keeps its value. The set in that register after an edge is used for the samples captured at that same edge.
- R5: Suppose the accumulate control is low for a sample and for the sample after it. Then `result_o` after the third rising edge after that sample's capture equals that sample's sum.
- R6: When a sample is captured with `acc_mode_i` high, `result_o` does not change on the second edge after that capture, which is when that sample is processed.
- R7: A sample captured with `acc_mode_i` low replaces the running total with its own sum. It also loads `result_o` with the prior total: the sum of the previous low-control sample plus every high-control sample since. A sample captured high adds its sum into the running total, which wraps modulo 2^32.
- R8: A coefficient write (`cw_en_i` high at a rising edge) stores `cw_data_i` at bank `cw_bank_i` (0..7) and set `cw_addr_i`. Samples captured at that same edge or later use the new value. Other banks and sets are unchanged.
- R9: Extremes are exact. Eight samples of -2048 times coefficients of -2048 give +33554432. Samples of 2047 times coefficients of -2048 give -33538048.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| tap_i | input | 96 | Eight 12-bit signed tap samples, tap k at bits [12k+11:12k] |
| set_addr_i | input | 8 | Coefficient set address |
| set_addr_en_n_i | input | 1 | Active-low load enable for the set address register |
| acc_mode_i | input | 1 | Accumulate control: 1 adds into the running total, 0 restarts it and publishes |
| cw_en_i | input | 1 | Coefficient write strobe |
| cw_bank_i | input | 3 | Coefficient bank (tap index) to write |
| cw_addr_i | input | 8 | Coefficient set to write |
| cw_data_i | input | 12 | Coefficient value, signed |
| result_o | output | 32 | Registered signed result |

## Verification
Several properties are checked on every cycle after reset. The set address register must hold while its enable is high and load the presented address while it is low. The result must stay frozen whenever the sample being processed was captured in accumulate mode. It must equal the prior running total whenever a restart is processed. Reset must clear the result and the total. The arithmetic itself can only be shown by the bench scenarios against an independently computed sum. Those scenarios cover the tap-to-bank mapping, the three-edge latency, the chained totals under irregular accumulate patterns, write-then-read visibility and the signed extremes.

// File: rtl/vfir_pkg.sv
// Package: shared sizing constants for the vertical FIR multiply-accumulate core.
// Assumes: all users take their parameter defaults from here.
package vfir_pkg;
    localparam int VF_TAPS   = 8;   // vertical taps per output
    localparam int VF_DATA_W = 12;  // sample width, two's complement
    localparam int VF_COEF_W = 12;  // coefficient width, two's complement
    localparam int VF_SET_W  = 8;   // coefficient set address width
    localparam int VF_ACC_W  = 32;  // running total and result width
endpackage : vfir_pkg

// File: rtl/vfir_coef_store.sv
// Module: vfir_coef_store
// Holds one coefficient bank per tap, each SETS deep, and a registered set
// address with active-low load enable. Reads are combinational from the
// registered address so the selected row lines up with taps captured at the
// same edge. Writes land on the clock edge and are seen by the next read.
// Assumes: the bank array is not reset; software fills it before use.
module vfir_coef_store #(
    parameter int TAPS   = vfir_pkg::VF_TAPS,
    parameter int COEF_W = vfir_pkg::VF_COEF_W,
    parameter int SET_W  = vfir_pkg::VF_SET_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [$clog2(TAPS)-1:0]   wr_bank,
    input  logic [SET_W-1:0]          wr_set,
    input  logic [COEF_W-1:0]         wr_data,
    input  logic                      sel_en_n,
    input  logic [SET_W-1:0]          sel_set_i,
    output logic [SET_W-1:0]          sel_set_q,
    output logic [TAPS*COEF_W-1:0]    coef_o
);
    localparam int SETS   = 1 << SET_W;
    localparam int BANK_W = $clog2(TAPS);

    // Set address register: loads only while the enable is low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_set_q <= '0;
        end else if (!sel_en_n) begin
            sel_set_q <= sel_set_i;
        end
    end

    for (genvar b = 0; b < TAPS; b++) begin : g_bank
        logic [COEF_W-1:0] mem [SETS];

        // Bank write: one word per edge, selected by bank index.
        always_ff @(posedge clk) begin
            if (wr_en && (wr_bank == BANK_W'(b))) begin
                mem[wr_set] <= wr_data;
            end
        end

        assign coef_o[b*COEF_W +: COEF_W] = mem[sel_set_q];
    end
endmodule : vfir_coef_store

// File: rtl/vfir_tap_mult.sv
// Module: vfir_tap_mult
// Registers the tap samples and forms one signed product per tap against the
// coefficient row supplied alongside. Products are exact at DATA_W+COEF_W.
// Assumes: coef_i is already aligned with the registered samples.
module vfir_tap_mult #(
    parameter int TAPS   = vfir_pkg::VF_TAPS,
    parameter int DATA_W = vfir_pkg::VF_DATA_W,
    parameter int COEF_W = vfir_pkg::VF_COEF_W,
    parameter int PROD_W = DATA_W + COEF_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [TAPS*DATA_W-1:0]  tap_i,
    input  logic [TAPS*COEF_W-1:0]  coef_i,
    output logic [TAPS*PROD_W-1:0]  prod_o
);
    logic [TAPS*DATA_W-1:0] tap_q;

    // Sample register: captures all taps every edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tap_q <= '0;
        end else begin
            tap_q <= tap_i;
        end
    end

    for (genvar k = 0; k < TAPS; k++) begin : g_mul
        logic signed [DATA_W-1:0] smp;
        logic signed [COEF_W-1:0] cof;
        logic signed [PROD_W-1:0] prd;

        assign smp = $signed(tap_q[k*DATA_W +: DATA_W]);
        assign cof = $signed(coef_i[k*COEF_W +: COEF_W]);
        assign prd = PROD_W'(smp) * PROD_W'(cof);
        assign prod_o[k*PROD_W +: PROD_W] = prd;
    end
endmodule : vfir_tap_mult

// File: rtl/vfir_sum_acc.sv
// Module: vfir_sum_acc
// Adds the tap products with sign extension into a registered sum, then
// either restarts or extends a running total. On a restart the previous
// total is published to the result register; while accumulating the result
// holds. The accumulate control is delayed to stay aligned with its sample.
// Assumes: ACC_W is wider than SUM_W; the running total wraps modulo 2^ACC_W.
module vfir_sum_acc #(
    parameter int TAPS   = vfir_pkg::VF_TAPS,
    parameter int PROD_W = vfir_pkg::VF_DATA_W + vfir_pkg::VF_COEF_W,
    parameter int SUM_W  = PROD_W + $clog2(TAPS),
    parameter int ACC_W  = vfir_pkg::VF_ACC_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [TAPS*PROD_W-1:0]  prod_i,
    input  logic                    acc_mode_i,
    output logic [ACC_W-1:0]        total_o,
    output logic [ACC_W-1:0]        result_o
);
    localparam int P_EXT = SUM_W - PROD_W;
    localparam int A_EXT = ACC_W - SUM_W;

    logic [SUM_W-1:0] tree_sum;
    logic [SUM_W-1:0] sum_q;
    logic [ACC_W-1:0] sum_ext;
    logic             mode_s0;
    logic             mode_s1;

    // Sum of products, each sign-extended to the tree width.
    always_comb begin
        tree_sum = '0;
        for (int k = 0; k < TAPS; k++) begin
            tree_sum = tree_sum + {{P_EXT{prod_i[k*PROD_W + PROD_W - 1]}},
                                   prod_i[k*PROD_W +: PROD_W]};
        end
    end

    assign sum_ext = {{A_EXT{sum_q[SUM_W-1]}}, sum_q};

    // Control alignment: mode travels with its sample through two stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_s0 <= 1'b0;
            mode_s1 <= 1'b0;
        end else begin
            mode_s0 <= acc_mode_i;
            mode_s1 <= mode_s0;
        end
    end

    // Sum register: holds the product total for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q <= '0;
        end else begin
            sum_q <= tree_sum;
        end
    end

    // Running total and result: extend while accumulating, else restart and publish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            total_o  <= '0;
            result_o <= '0;
        end else if (mode_s1) begin
            total_o  <= total_o + sum_ext;
        end else begin
            total_o  <= sum_ext;
            result_o <= total_o;
        end
    end
endmodule : vfir_sum_acc

// File: rtl/vfir_mac_core.sv
// Module: vfir_mac_core
// Top of the vertical FIR multiply-accumulate core: coefficient store with
// set address register, per-tap multipliers, sum and accumulate stage.
// Latency from sample capture to published result is three edges when the
// accumulate control stays low.
// Assumes: line delays outside supply the eight taps already aligned.
module vfir_mac_core #(
    parameter int TAPS   = vfir_pkg::VF_TAPS,
    parameter int DATA_W = vfir_pkg::VF_DATA_W,
    parameter int COEF_W = vfir_pkg::VF_COEF_W,
    parameter int SET_W  = vfir_pkg::VF_SET_W,
    parameter int ACC_W  = vfir_pkg::VF_ACC_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [TAPS*DATA_W-1:0]   tap_i,
    input  logic [SET_W-1:0]         set_addr_i,
    input  logic                     set_addr_en_n_i,
    input  logic                     acc_mode_i,
    input  logic                     cw_en_i,
    input  logic [$clog2(TAPS)-1:0]  cw_bank_i,
    input  logic [SET_W-1:0]         cw_addr_i,
    input  logic [COEF_W-1:0]        cw_data_i,
    output logic [ACC_W-1:0]         result_o
);
    localparam int PROD_W = DATA_W + COEF_W;
    localparam int SUM_W  = PROD_W + $clog2(TAPS);

    logic [SET_W-1:0]        sel_addr;
    logic [TAPS*COEF_W-1:0]  coef_row;
    logic [TAPS*PROD_W-1:0]  prod_row;
    logic [ACC_W-1:0]        acc_total;

    vfir_coef_store #(
        .TAPS   (TAPS),
        .COEF_W (COEF_W),
        .SET_W  (SET_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cw_en_i),
        .wr_bank   (cw_bank_i),
        .wr_set    (cw_addr_i),
        .wr_data   (cw_data_i),
        .sel_en_n  (set_addr_en_n_i),
        .sel_set_i (set_addr_i),
        .sel_set_q (sel_addr),
        .coef_o    (coef_row)
    );

    vfir_tap_mult #(
        .TAPS   (TAPS),
        .DATA_W (DATA_W),
        .COEF_W (COEF_W),
        .PROD_W (PROD_W)
    ) u_mult (
        .clk    (clk),
        .rst_n  (rst_n),
        .tap_i  (tap_i),
        .coef_i (coef_row),
        .prod_o (prod_row)
    );

    vfir_sum_acc #(
        .TAPS   (TAPS),
        .PROD_W (PROD_W),
        .SUM_W  (SUM_W),
        .ACC_W  (ACC_W)
    ) u_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .prod_i     (prod_row),
        .acc_mode_i (acc_mode_i),
        .total_o    (acc_total),
        .result_o   (result_o)
    );
endmodule : vfir_mac_core

// File: rtl/vfir_mac_core_chk.sv
// Module: vfir_mac_core_chk
// Temporal checks on the core, attached by bind. A small counter of edges
// since reset keeps every look-back inside the post-reset window.
module vfir_mac_core_chk #(
    parameter int SET_W = vfir_pkg::VF_SET_W,
    parameter int ACC_W = vfir_pkg::VF_ACC_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             acc_mode_i,
    input logic             set_addr_en_n_i,
    input logic [SET_W-1:0] set_addr_i,
    input logic [SET_W-1:0] sel_addr,
    input logic [ACC_W-1:0] acc_total,
    input logic [ACC_W-1:0] result_o
);
    logic [1:0] live_cnt;

    // Edges since reset release, saturating at three.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_cnt <= '0;
        end else if (live_cnt != 2'd3) begin
            live_cnt <= live_cnt + 2'd1;
        end
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (result_o == '0 && acc_total == '0));

    a_r4_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (live_cnt != 2'd0 && $past(set_addr_en_n_i)) |-> $stable(sel_addr));

    a_r4_addr_load: assert property (@(posedge clk) disable iff (!rst_n)
        (live_cnt != 2'd0 && !$past(set_addr_en_n_i)) |-> (sel_addr == $past(set_addr_i)));

    a_r6_result_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (live_cnt == 2'd3 && $past(acc_mode_i, 3)) |-> $stable(result_o));

    a_r7_publish_total: assert property (@(posedge clk) disable iff (!rst_n)
        (live_cnt == 2'd3 && !$past(acc_mode_i, 3)) |-> (result_o == $past(acc_total)));
endmodule : vfir_mac_core_chk

bind vfir_mac_core vfir_mac_core_chk #(
    .SET_W (SET_W),
    .ACC_W (ACC_W)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .acc_mode_i      (acc_mode_i),
    .set_addr_en_n_i (set_addr_en_n_i),
    .set_addr_i      (set_addr_i),
    .sel_addr        (sel_addr),
    .acc_total       (acc_total),
    .result_o        (result_o)
);

// File: tb/vfir_mac_core_tb.sv
// Bench: fills every coefficient word, sweeps all sets and several tap and
// control patterns, and compares the result every cycle against an
// arithmetic model built from the requirements.
module vfir_mac_core_tb;
    localparam int NT = 8;
    localparam int DW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NT*DW-1:0] tap_i = '0;
    logic [7:0]    set_addr_i = '0;
    logic          set_addr_en_n_i = 1'b0;
    logic          acc_mode_i = 1'b0;
    logic          cw_en_i = 1'b0;
    logic [2:0]    cw_bank_i = '0;
    logic [7:0]    cw_addr_i = '0;
    logic [11:0]   cw_data_i = '0;
    logic [31:0]   result_o;

    int n_checks = 0;
    int n_fail = 0;
    bit chk_on = 1'b0;
    bit done = 1'b0;
    string cur_req = "R1";

    // Model state
    int cm [NT][256];
    int m_addr = 0, p1_sum = 0, p2_sum = 0, m_acc = 0, m_res = 0;
    bit p1_c = 0, p2_c = 0;

    always #5 clk = ~clk;

    vfir_mac_core u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .tap_i           (tap_i),
        .set_addr_i      (set_addr_i),
        .set_addr_en_n_i (set_addr_en_n_i),
        .acc_mode_i      (acc_mode_i),
        .cw_en_i         (cw_en_i),
        .cw_bank_i       (cw_bank_i),
        .cw_addr_i       (cw_addr_i),
        .cw_data_i       (cw_data_i),
        .result_o        (result_o)
    );

    // Reference model from R2..R8: capture, sum stage, accumulate stage.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_addr = 0; p1_sum = 0; p2_sum = 0; m_acc = 0; m_res = 0;
            p1_c = 0; p2_c = 0;
        end else begin
            int s;
            if (p2_c) m_acc = m_acc + p2_sum;
            else begin m_res = m_acc; m_acc = p2_sum; end
            p2_sum = p1_sum; p2_c = p1_c;
            if (cw_en_i) cm[cw_bank_i][cw_addr_i] = int'($signed(cw_data_i));
            if (!set_addr_en_n_i) m_addr = int'(set_addr_i);
            s = 0;
            for (int k = 0; k < NT; k++)
                s += int'($signed(tap_i[k*DW +: DW])) * cm[k][m_addr];
            p1_sum = s; p1_c = acc_mode_i;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: result_o=%0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (chk_on) check(cur_req, $signed(result_o), m_res);
    end

    function automatic logic [NT*DW-1:0] taps_of(input int n);
        logic [NT*DW-1:0] v;
        for (int k = 0; k < NT; k++) v[k*DW +: DW] = 12'(n*173 + k*911 + n*k*7 + 5);
        return v;
    endfunction

    function automatic logic [11:0] cpat(input int b, input int a);
        if (a == 255) return 12'h800;
        if (a == 254) return 12'h7FF;
        return 12'(b*389 + a*57 + a*a*3 + 1);
    endfunction

    function automatic logic [NT*DW-1:0] all_taps(input logic [11:0] v);
        logic [NT*DW-1:0] r;
        for (int k = 0; k < NT; k++) r[k*DW +: DW] = v;
        return r;
    endfunction

    task automatic cyc(input logic [NT*DW-1:0] t, input int a, input bit en_n, input bit am);
        tap_i = t; set_addr_i = 8'(a); set_addr_en_n_i = en_n; acc_mode_i = am;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    endtask

    initial begin
        foreach (cm[b, a]) cm[b][a] = 0;
        @(negedge clk);
        // R1: reset with busy inputs
        for (int i = 0; i < 4; i++) cyc(taps_of(i), i, 1'b0, i[0]);
        check("R1", $signed(result_o), 0);
        rst_n = 1'b1;
        chk_on = 1'b1;
        // R8: fill every coefficient word, taps zero so result stays zero (R1)
        for (int b = 0; b < NT; b++)
            for (int a = 0; a < 256; a++) begin
                cw_en_i = 1'b1; cw_bank_i = 3'(b); cw_addr_i = 8'(a); cw_data_i = cpat(b, a);
                cyc('0, 0, 1'b0, 1'b0);
            end
        cw_en_i = 1'b0;
        check("R1", $signed(result_o), 0);
        // R2, R3, R5: all sets, varied taps, plain mode
        cur_req = "R5";
        for (int n = 0; n < 768; n++) cyc(taps_of(n), n % 256, 1'b0, 1'b0);
        // R4: address enable toggling
        cur_req = "R4";
        for (int n = 0; n < 300; n++) cyc(taps_of(n + 7), n * 13, ((n / 7) % 2) == 1, 1'b0);
        // R6, R7: irregular accumulate runs
        cur_req = "R7";
        for (int n = 0; n < 600; n++) cyc(taps_of(n * 3 + 1), n * 3, 1'b0, ((n * 5) % 11) < 6);
        for (int n = 0; n < 40; n++) cyc(taps_of(n + 900), n, 1'b0, 1'b1);
        for (int n = 0; n < 4; n++) cyc(taps_of(n), n, 1'b0, 1'b0);
        // R8: rewrite the active set and a neighbour while reading
        cur_req = "R8";
        for (int n = 0; n < 64; n++) begin
            cw_en_i = 1'b1; cw_bank_i = 3'(n % NT);
            cw_addr_i = (n % 3 == 0) ? 8'd18 : 8'd17;
            cw_data_i = 12'(n * 301 + 77);
            cyc(taps_of(n + 40), 17, 1'b0, 1'b0);
        end
        cw_en_i = 1'b0;
        // R9: signed extremes
        cur_req = "R9";
        for (int n = 0; n < 6; n++) cyc(all_taps(12'h800), 255, 1'b0, 1'b0);
        check("R9", $signed(result_o), 33554432);
        for (int n = 0; n < 6; n++) cyc(all_taps(12'h7FF), 255, 1'b0, 1'b0);
        check("R9", $signed(result_o), -33538048);
        for (int n = 0; n < 6; n++) cyc(all_taps(12'h800), 254, 1'b0, 1'b0);
        check("R9", $signed(result_o), -33538048);
        // R1: reset in the middle of a chain
        cur_req = "R1";
        for (int n = 0; n < 5; n++) cyc(taps_of(n), n, 1'b0, 1'b1);
        rst_n = 1'b0;
        cyc(taps_of(9), 3, 1'b0, 1'b1);
        check("R1", $signed(result_o), 0);
        rst_n = 1'b1;
        for (int n = 0; n < 8; n++) cyc(taps_of(n + 50), n, 1'b0, 1'b0);
        chk_on = 1'b0;
        done = 1'b1;
        summary();
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            summary();
            $finish;
        end
    end
endmodule : vfir_mac_core_tb